// File: doc/BRIEF.md
# Execution Signature Fault Classifier

This block sits beside a processor under test and watches its execution trace. Each clock cycle of an active run it folds six 32-bit trace words into a running CRC-32 signature: program counter, data address, data value, fetch address, register-file write data and control-register write data. It compares the signature with a golden value supplied in the same cycle. That golden value comes from a stream recorded during an earlier fault-free run of the same program.

The block also watches the core's two alert lines, which carry minor and major severity. It ties the first signature divergence to those alerts and sorts the run into one of four outcomes: no effect, detected fault, undetected fault or false positive. The first outcome that occurs is latched. When a fault is detected, the block raises a stop request so the environment can end the run.

The trace is sampled every cycle while `run_en` is high. There is no back-pressure: the block accepts a trace beat in every active cycle, and the environment must present the golden value for that same cycle. A synchronous `clr` prepares the block for the next run.

Top module: `sig_fault_classifier`

## Requirements
- R1: While `run_en` is high and `clr` is low, `sig_live` takes its next CRC value at every rising clock edge. While `run_en` is low, `sig_live` holds its value.
- R2: The CRC is non-reflected CRC-32 with polynomial 0x04C11DB7, start value 0xFFFFFFFF and no final inversion. Each update shifts in 192 bits, most significant bit first, formed as {pc, data address, data value, fetch address, register write data, control-register write data}.
- R3: `sig_mismatch` is high, in the same cycle and with no register in the path, exactly when `run_en` is high and `sig_live` differs from `gold_sig`.
- R4: A mismatch in a cycle where `alert_minor` or `alert_major` is high latches outcome 2'b01 (detected) and raises `stop_req` from the next clock edge.
- R5: If the first mismatch has no alert in its own cycle, an alert of either severity in any of the following 4 cycles also latches 2'b01 and raises `stop_req`.
- R6: If no alert appears in the cycle of the first mismatch or in the 4 cycles that follow, outcome 2'b10 (undetected) is latched at the edge that ends the 4th following cycle, and `stop_req` stays low.
- R7: An alert during an active run, while the signature matches and no mismatch is pending, latches 2'b11 (false positive) with `stop_req` low. Alerts while `run_en` is low and nothing is pending have no effect.
- R8: Outcome 2'b00 means no effect. Once a non-zero outcome has latched, it and `stop_req` stay fixed against all later mismatches and alerts until a clear.
- R9: A high `clr` at a clock edge sets `sig_live` to 0xFFFFFFFF, sets the outcome to 2'b00, drops `stop_req` and cancels any pending alert window. It takes priority over `run_en`. The asynchronous active-low `rst_n` does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear before a run |
| run_en | input | 1 | Run active; trace sampled this cycle |
| trc_pc | input | 32 | Program counter |
| trc_daddr | input | 32 | Data access address |
| trc_ddata | input | 32 | Data access value |
| trc_iaddr | input | 32 | Instruction fetch address |
| trc_rfwd | input | 32 | Register file write data |
| trc_csrwd | input | 32 | Control-register write data |
| gold_sig | input | 32 | Golden signature for this cycle |
| alert_minor | input | 1 | Minor-severity alert from the core |
| alert_major | input | 1 | Major-severity alert from the core |
| sig_live | output | 32 | Current running signature |
| sig_mismatch | output | 1 | Live signature differs from golden |
| stop_req | output | 1 | Request to stop the run (detected fault) |
| outcome | output | 2 | Latched run outcome code |

## Verification
A corrupted signature register shows on `sig_live` at the first edge after the bad update. Through the golden comparison it raises `sig_mismatch` in that same cycle. A wrong window counter or classifier state cannot be seen until an outcome latches. It then shows as a wrong code, or a code at the wrong edge, within five cycles of the first mismatch. A classifier that fails to hold or clear shows at the edge after the next alert or clear. Each of these checks samples at a known edge rather than waiting for the run to end.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'b00,
    OUT_DET   = 2'b01,
    OUT_UNDET = 2'b10,
    OUT_FALSE = 2'b11
  } outcome_e;

  typedef enum logic [1:0] {
    CL_IDLE = 2'b00,
    CL_WAIT = 2'b01,
    CL_DONE = 2'b10
  } cls_state_e;

endpackage

// File: rtl/sfc_trace_pack.sv
module sfc_trace_pack #(
  parameter int TW = 32,
  parameter int NW = 6,
  localparam int DW = TW * NW
) (
  input  logic [NW-1:0][TW-1:0] words,
  output logic [DW-1:0]         beat
);
  // words[NW-1] lands in the most significant slot
  for (genvar k = 0; k < NW; k++) begin : g_slot
    assign beat[k*TW +: TW] = words[k];
  end
endmodule

// File: rtl/sfc_crc_engine.sv
module sfc_crc_engine #(
  parameter int          SW   = 32,
  parameter int          DW   = 192,
  parameter logic [SW-1:0] POLY = 32'h04C11DB7,
  parameter logic [SW-1:0] INIT = 32'hFFFFFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] beat,
  output logic [SW-1:0] sig
);

  function automatic logic [SW-1:0] fold(input logic [SW-1:0] c_in,
                                         input logic [DW-1:0] d);
    logic [SW-1:0] c;
    logic          fb;
    c = c_in;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[SW-1] ^ d[i];
      c  = {c[SW-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic [SW-1:0] sig_q;
  logic [SW-1:0] sig_nxt;

  assign sig_nxt = fold(sig_q, beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= INIT;
    else if (clr)    sig_q <= INIT;
    else if (en)     sig_q <= sig_nxt;
  end

  assign sig = sig_q;

  p_clear_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == INIT));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(sig_q));

endmodule

// File: rtl/sfc_classifier.sv
module sfc_classifier
  import sfc_pkg::*;
#(
  parameter int ALERT_WIN = 4,
  localparam int CW = $clog2(ALERT_WIN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run_en,
  input  logic       mismatch,
  input  logic       alert,
  output logic [1:0] outcome,
  output logic       stop_req
);

  cls_state_e    state_q;
  outcome_e      outc_q;
  logic          stop_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CL_IDLE;
      outc_q  <= OUT_NONE;
      stop_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (clr) begin
      state_q <= CL_IDLE;
      outc_q  <= OUT_NONE;
      stop_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CL_IDLE: begin
          if (run_en) begin
            if (mismatch && alert) begin
              outc_q  <= OUT_DET;
              stop_q  <= 1'b1;
              state_q <= CL_DONE;
            end else if (mismatch) begin
              cnt_q   <= '0;
              state_q <= CL_WAIT;
            end else if (alert) begin
              outc_q  <= OUT_FALSE;
              state_q <= CL_DONE;
            end
          end
        end
        CL_WAIT: begin
          if (alert) begin
            outc_q  <= OUT_DET;
            stop_q  <= 1'b1;
            state_q <= CL_DONE;
          end else if (cnt_q == CW'(ALERT_WIN - 1)) begin
            outc_q  <= OUT_UNDET;
            state_q <= CL_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign outcome  = outc_q;
  assign stop_req = stop_q;

  p_outcome_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outc_q != OUT_NONE && !clr) |=> (outc_q == $past(outc_q)));

  p_stop_det_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (outc_q == OUT_DET));

  p_win_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(ALERT_WIN));

  p_clear_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (outc_q == OUT_NONE && !stop_q));

endmodule

// File: rtl/sig_fault_classifier.sv
module sig_fault_classifier #(
  parameter int            TW        = 32,
  parameter int            SW        = 32,
  parameter logic [SW-1:0] POLY      = 32'h04C11DB7,
  parameter logic [SW-1:0] INIT      = 32'hFFFFFFFF,
  parameter int            ALERT_WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run_en,
  input  logic [TW-1:0] trc_pc,
  input  logic [TW-1:0] trc_daddr,
  input  logic [TW-1:0] trc_ddata,
  input  logic [TW-1:0] trc_iaddr,
  input  logic [TW-1:0] trc_rfwd,
  input  logic [TW-1:0] trc_csrwd,
  input  logic [SW-1:0] gold_sig,
  input  logic          alert_minor,
  input  logic          alert_major,
  output logic [SW-1:0] sig_live,
  output logic          sig_mismatch,
  output logic          stop_req,
  output logic [1:0]    outcome
);

  localparam int NW = 6;
  localparam int DW = TW * NW;

  logic [NW-1:0][TW-1:0] words;
  logic [DW-1:0]         beat;
  logic [SW-1:0]         sig;
  logic                  any_alert;

  assign words = {trc_pc, trc_daddr, trc_ddata, trc_iaddr, trc_rfwd, trc_csrwd};

  sfc_trace_pack #(.TW(TW), .NW(NW)) u_pack (
    .words (words),
    .beat  (beat)
  );

  sfc_crc_engine #(.SW(SW), .DW(DW), .POLY(POLY), .INIT(INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (run_en),
    .beat  (beat),
    .sig   (sig)
  );

  assign sig_live     = sig;
  assign sig_mismatch = run_en && (sig != gold_sig);
  assign any_alert    = alert_minor | alert_major;

  sfc_classifier #(.ALERT_WIN(ALERT_WIN)) u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .run_en   (run_en),
    .mismatch (sig_mismatch),
    .alert    (any_alert),
    .outcome  (outcome),
    .stop_req (stop_req)
  );

endmodule

// File: tb/sig_fault_classifier_tb.sv
module sig_fault_classifier_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        run_en = 1'b0;
  logic [31:0] trc_pc = '0, trc_daddr = '0, trc_ddata = '0;
  logic [31:0] trc_iaddr = '0, trc_rfwd = '0, trc_csrwd = '0;
  logic [31:0] gold_sig = '0;
  logic        alert_minor = 1'b0, alert_major = 1'b0;
  logic [31:0] sig_live;
  logic        sig_mismatch, stop_req;
  logic [1:0]  outcome;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_sig = 32'hFFFFFFFF;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sig_fault_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_en(run_en),
    .trc_pc(trc_pc), .trc_daddr(trc_daddr), .trc_ddata(trc_ddata),
    .trc_iaddr(trc_iaddr), .trc_rfwd(trc_rfwd), .trc_csrwd(trc_csrwd),
    .gold_sig(gold_sig), .alert_minor(alert_minor), .alert_major(alert_major),
    .sig_live(sig_live), .sig_mismatch(sig_mismatch),
    .stop_req(stop_req), .outcome(outcome)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R2 reference: MSB-first shift of 192 bits, poly 0x04C11DB7, no reflection
  function automatic logic [31:0] ref_crc(input logic [31:0] c_in,
                                          input logic [191:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 191; i >= 0; i--) begin
      if (c[31] ^ d[i]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  task automatic new_trace();
    seed = seed * 32'd1664525 + 32'd1013904223; trc_pc    = seed;
    seed = seed * 32'd1664525 + 32'd1013904223; trc_daddr = seed;
    seed = seed * 32'd1664525 + 32'd1013904223; trc_ddata = seed;
    seed = seed * 32'd1664525 + 32'd1013904223; trc_iaddr = seed;
    seed = seed * 32'd1664525 + 32'd1013904223; trc_rfwd  = seed;
    seed = seed * 32'd1664525 + 32'd1013904223; trc_csrwd = seed;
  endtask

  // one active cycle, entered and left just after a falling edge
  task automatic cyc(input bit mis, input bit amin, input bit amaj);
    new_trace();
    run_en = 1'b1;
    gold_sig = mis ? (exp_sig ^ 32'h1) : exp_sig;
    alert_minor = amin;
    alert_major = amaj;
    #1;
    chk(sig_mismatch == mis, "R3 mismatch flag", {31'd0, sig_mismatch}, {31'd0, mis});
    @(posedge clk);
    exp_sig = ref_crc(exp_sig, {trc_pc, trc_daddr, trc_ddata, trc_iaddr, trc_rfwd, trc_csrwd});
    @(negedge clk);
    run_en = 1'b0;
    alert_minor = 1'b0;
    alert_major = 1'b0;
  endtask

  task automatic idle(input bit amin, input bit amaj);
    run_en = 1'b0;
    alert_minor = amin;
    alert_major = amaj;
    @(negedge clk);
    alert_minor = 1'b0;
    alert_major = 1'b0;
  endtask

  task automatic do_clear(input bit with_run);
    clr = 1'b1;
    run_en = with_run;
    alert_major = with_run;
    gold_sig = ~sig_live;
    @(negedge clk);
    clr = 1'b0;
    run_en = 1'b0;
    alert_major = 1'b0;
    exp_sig = 32'hFFFFFFFF;
  endtask

  task automatic expect_out(input logic [1:0] o, input bit s, input string tag);
    chk(outcome == o, tag, {30'd0, outcome}, {30'd0, o});
    chk(stop_req == s, tag, {31'd0, stop_req}, {31'd0, s});
  endtask

  task automatic t_reset();
    chk(sig_live == 32'hFFFFFFFF, "R9 reset signature", sig_live, 32'hFFFFFFFF);
    expect_out(2'b00, 1'b0, "R9 reset outcome");
    chk(sig_mismatch == 1'b0, "R3 idle no mismatch", {31'd0, sig_mismatch}, 32'd0);
  endtask

  task automatic t_crc();
    do_clear(1'b0);
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, 1'b0, 1'b0);
      chk(sig_live == exp_sig, "R2 signature value", sig_live, exp_sig);
    end
    for (int k = 0; k < 3; k++) begin
      new_trace();
      idle(1'b0, 1'b0);
      chk(sig_live == exp_sig, "R1 hold while idle", sig_live, exp_sig);
    end
    gold_sig = ~exp_sig;
    #1;
    chk(sig_mismatch == 1'b0, "R3 masked when idle", {31'd0, sig_mismatch}, 32'd0);
    expect_out(2'b00, 1'b0, "R8 clean run no effect");
  endtask

  task automatic t_detect_same();
    do_clear(1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    expect_out(2'b01, 1'b1, "R4 detected same cycle");
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    idle(1'b0, 1'b0); idle(1'b0, 1'b0); idle(1'b0, 1'b0);
    idle(1'b0, 1'b0); idle(1'b0, 1'b0);
    expect_out(2'b01, 1'b1, "R8 detected held");
  endtask

  task automatic t_detect_late();
    do_clear(1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 1'b0);
      expect_out(2'b00, 1'b0, "R5 window open");
    end
    cyc(1'b0, 1'b0, 1'b1);
    expect_out(2'b01, 1'b1, "R5 detected at last window cycle");
  endtask

  task automatic t_undetected();
    do_clear(1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      idle(1'b0, 1'b0);
      expect_out(2'b00, 1'b0, "R6 pending");
    end
    idle(1'b0, 1'b0);
    expect_out(2'b10, 1'b0, "R6 undetected latched");
    cyc(1'b0, 1'b1, 1'b0);
    expect_out(2'b10, 1'b0, "R8 late alert ignored");
  endtask

  task automatic t_false_pos();
    do_clear(1'b0);
    idle(1'b1, 1'b1);
    expect_out(2'b00, 1'b0, "R7 idle alert ignored");
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    expect_out(2'b11, 1'b0, "R7 false positive");
    cyc(1'b1, 1'b1, 1'b0);
    expect_out(2'b11, 1'b0, "R8 false positive held");
  endtask

  task automatic t_clear();
    do_clear(1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    expect_out(2'b01, 1'b1, "R4 detected before clear");
    do_clear(1'b1);
    chk(sig_live == 32'hFFFFFFFF, "R9 clear signature", sig_live, 32'hFFFFFFFF);
    expect_out(2'b00, 1'b0, "R9 clear beats run");
    cyc(1'b1, 1'b0, 1'b0);
    do_clear(1'b0);
    for (int k = 0; k < 5; k++) idle(1'b0, 1'b0);
    expect_out(2'b00, 1'b0, "R9 window cancelled");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_crc();
    t_detect_same();
    t_detect_late();
    t_undetected();
    t_false_pos();
    t_clear();
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #200000;
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule